// File: doc/BRIEF.md
# 8b/10b Codeword Decoder with Ranked Error Reporting

This block takes 10-bit line codewords, already aligned to character boundaries and qualified by a valid strobe, and turns each one back into a byte. A control-character flag, an error flag and a mark flag come with each byte. The mark flag has two meanings. On an error-free word it singles out the comma character K28.5. On an errored word it tells an illegal code apart from a running-disparity violation. The block keeps the running disparity across words and updates it from the received bits of every accepted word, including errored ones.

When one word meets several reportable conditions, a fixed ranking decides which one is shown: an illegal code first, then a disparity violation, then the comma. All five outputs for a word come from one register stage, so they always describe the same codeword. The result appears exactly one clock after the word is accepted.

Top module: `b10_decoder`

## Requirements
- R1: `inCode[9:0]` carries the sub-blocks as {a,b,c,d,e,i,f,g,h,j}, where a is bit 9. `outData[7:0]` is {H,G,F,E,D,C,B,A}. Every legal data codeword, sent with the running disparity its encoding expects, gives its byte with `outCtrl`=0, `outErr`=0 and `outMark`=0.
- R2: The twelve control codewords (K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7), in either polarity and with the matching disparity, give `outCtrl`=1, `outErr`=0 and their byte value (K28.5 = 0xBC).
- R3: `outMark`=1 with `outErr`=0 happens for K28.5 only, and then `outCtrl`=1. Every other error-free word gives `outMark`=0.
- R4: A word is illegal when any of these holds: its 6-bit block is not in the code set; its 4-bit block is 0000 or 1111; it uses the alternate 0111/1000 form of y=7 without a 5-bit value and polarity that call for it; or it uses the primary 1110/0001 form where the alternate form is required (including after a K28 block). An illegal word gives `outErr`=1 and `outMark`=0.
- R5: A legal word is a disparity error in any of these cases: a 6-bit or 4-bit block with more ones than zeros arrives while disparity is positive; a block with more zeros than ones arrives while disparity is negative; or one of the balanced but polarity-bound blocks (111000, 000111, 1100, 0011) arrives at the wrong disparity. The 4-bit block is judged against the disparity after the 6-bit block. A disparity error gives `outErr`=1 and `outMark`=1.
- R6: Ranking is illegal word, then disparity error, then comma. Whenever `outErr`=1, `outCtrl`=0.
- R7: Running disparity is negative after reset. Each accepted word updates it from its received bits, errored words included. For each block, more ones gives positive, more zeros gives negative, and an equal count leaves it unchanged.
- R8: `outValid` is high in the cycle after each cycle with `inValid` high, and low otherwise.
- R9: Cycles with `inValid` low change neither the running disparity nor any data, flag or mark output.
- R10: During reset, `outValid`, `outErr`, `outMark`, `outCtrl` and `outData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `inCode` in this cycle |
| inCode | input | 10 | Aligned codeword, bit 9 is a |
| outValid | output | 1 | Result for the word accepted one cycle earlier |
| outData | output | 8 | Decoded byte, bit 7 is H |
| outCtrl | output | 1 | Control character received |
| outErr | output | 1 | Word is illegal or breaks disparity |
| outMark | output | 1 | Comma when error-free; error kind when `outErr` |

## Verification
The main decode is driven with an unbroken stream of all 256 data bytes, encoded by the bench with its own running disparity. This separates a wrong byte mapping from a wrong disparity update, because one slip in the disparity turns every later word into an error. The control set is sent in both polarities, with a disparity-flipping data word placed between them when needed. This shows the K28.5 mark apart from the other eleven control codes. Handmade codewords then trigger each kind of error alone and both kinds together, to show the ranking. After illegal words that force the disparity to a known value, polarity-sensitive words check that the update still follows the received bits. An idle gap with unbalanced garbage on the code input checks that nothing moves while the strobe is low.

// File: rtl/b10_pkg.sv
`timescale 1ns/1ps
package b10_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 10;
  localparam int HI_W   = 6;
  localparam int LO_W   = 4;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;
  localparam int X_CNT  = 1 << X_W;
  localparam int Y_CNT  = 1 << Y_W;

  typedef struct packed {
    logic invalid;
    logic dispErr;
    logic isK;
    logic comma;
  } decFlags_t;

  typedef struct packed {
    logic load;
    logic err;
    logic mark;
    logic ctrl;
  } outStrobe_t;

  // 6-bit block sent at negative disparity, indexed by the 5-bit value
  function automatic logic [HI_W-1:0] sixNeg(input logic [X_W-1:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // positive-disparity form: complement when unbalanced or polarity-bound
  function automatic logic [HI_W-1:0] sixPos(input logic [X_W-1:0] x);
    logic [HI_W-1:0] n;
    n = sixNeg(x);
    return ($countones(n) == 3 && x != 5'd7) ? n : ~n;
  endfunction

  function automatic logic [LO_W-1:0] fourNeg(input logic [Y_W-1:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [LO_W-1:0] fourPos(input logic [Y_W-1:0] y);
    logic [LO_W-1:0] n;
    n = fourNeg(y);
    return ($countones(n) == 2 && y != 3'd3) ? n : ~n;
  endfunction
endpackage

// File: rtl/b10_datapath.sv
`timescale 1ns/1ps
module b10_datapath
  import b10_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] inCode,
  input  outStrobe_t        strobe,
  output decFlags_t         flags,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outCtrl,
  output logic              outErr,
  output logic              outMark
);
  logic            rd;
  logic [HI_W-1:0] s6;
  logic [LO_W-1:0] s4, t4;
  logic [X_W-1:0]  xVal;
  logic [Y_W-1:0]  yVal;
  logic found6, found4, isK28, altSeven, priSeven;
  logic xSetA, xSetB, xSetK, badAlt, rdMid, rdNext, dispHi, dispLo;
  int   ones6, ones4;

  assign s6 = inCode[CODE_W-1:LO_W];
  assign s4 = inCode[LO_W-1:0];

  // 6-bit block: reverse lookup over both polarities
  always_comb begin
    found6 = 1'b0;
    xVal   = '0;
    for (int i = 0; i < X_CNT; i++) begin
      if (s6 == sixNeg(X_W'(i)) || s6 == sixPos(X_W'(i))) begin
        found6 = 1'b1;
        xVal   = X_W'(i);
      end
    end
    isK28 = (s6 == 6'b001111) || (s6 == 6'b110000);
    if (isK28) begin
      found6 = 1'b1;
      xVal   = 5'd28;
    end
  end

  // 4-bit block: K28 at positive entry arrives inverted
  always_comb begin
    t4       = (s6 == 6'b110000) ? ~s4 : s4;
    found4   = 1'b0;
    yVal     = '0;
    for (int j = 0; j < Y_CNT; j++) begin
      if (t4 == fourNeg(Y_W'(j)) || t4 == fourPos(Y_W'(j))) begin
        found4 = 1'b1;
        yVal   = Y_W'(j);
      end
    end
    if (t4 == 4'b0111 || t4 == 4'b1000) begin
      found4 = 1'b1;
      yVal   = 3'd7;
    end
    altSeven = (s4 == 4'b0111) || (s4 == 4'b1000);
    priSeven = (s4 == 4'b1110) || (s4 == 4'b0001);
  end

  // legality of the y=7 forms and the disparity chain
  always_comb begin
    xSetA  = (xVal == 5'd17) || (xVal == 5'd18) || (xVal == 5'd20);
    xSetB  = (xVal == 5'd11) || (xVal == 5'd13) || (xVal == 5'd14);
    xSetK  = (xVal == 5'd23) || (xVal == 5'd27) || (xVal == 5'd29) || (xVal == 5'd30);
    badAlt = (altSeven && !isK28 && !xSetK && !(xSetA && s4 == 4'b0111)
                                          && !(xSetB && s4 == 4'b1000))
          || (priSeven && (isK28 || (xSetA && s4 == 4'b1110)
                                 || (xSetB && s4 == 4'b0001)));
    ones6  = $countones(s6);
    ones4  = $countones(s4);
    rdMid  = (ones6 == 3) ? rd : (ones6 > 3);
    rdNext = (ones4 == 2) ? rdMid : (ones4 > 2);
    dispHi = (ones6 == 4 && rd) || (ones6 == 2 && !rd)
          || (s6 == 6'b111000 && rd) || (s6 == 6'b000111 && !rd);
    dispLo = (ones4 == 3 && rdMid) || (ones4 == 1 && !rdMid)
          || (s4 == 4'b1100 && rdMid) || (s4 == 4'b0011 && !rdMid);
    flags.invalid = !found6 || !found4 || badAlt;
    flags.dispErr = dispHi || dispLo;
    flags.isK     = isK28 || (altSeven && xSetK);
    flags.comma   = isK28 && (yVal == 3'd5);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rd       <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
      outCtrl  <= 1'b0;
      outErr   <= 1'b0;
      outMark  <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        rd      <= rdNext;
        outData <= {yVal, xVal};
        outCtrl <= strobe.ctrl;
        outErr  <= strobe.err;
        outMark <= strobe.mark;
      end
    end
  end
endmodule

// File: rtl/b10_control.sv
`timescale 1ns/1ps
module b10_control
  import b10_pkg::*;
(
  input  logic       inValid,
  input  decFlags_t  flags,
  output outStrobe_t strobe
);
  // fixed ranking: illegal word, then disparity, then comma
  always_comb begin
    strobe.load = inValid;
    strobe.err  = flags.invalid || flags.dispErr;
    if (flags.invalid)      strobe.mark = 1'b0;
    else if (flags.dispErr) strobe.mark = 1'b1;
    else                    strobe.mark = flags.comma;
    strobe.ctrl = !strobe.err && flags.isK;
  end
endmodule

// File: rtl/b10_decoder.sv
`timescale 1ns/1ps
module b10_decoder
  import b10_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outCtrl,
  output logic              outErr,
  output logic              outMark
);
  decFlags_t  flags;
  outStrobe_t strobe;

  b10_control i_control (
    .inValid (inValid),
    .flags   (flags),
    .strobe  (strobe)
  );

  b10_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inCode   (inCode),
    .strobe   (strobe),
    .flags    (flags),
    .outValid (outValid),
    .outData  (outData),
    .outCtrl  (outCtrl),
    .outErr   (outErr),
    .outMark  (outMark)
  );
endmodule

// File: rtl/b10_checker.sv
`timescale 1ns/1ps
module b10_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [9:0] inCode,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outCtrl,
  input logic       outErr,
  input logic       outMark
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData) && $stable(outErr) && $stable(outMark) && $stable(outCtrl));

  a_r6_err_clears_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> !outCtrl);

  a_r3_comma_is_k28_5: assert property (@(posedge clk) disable iff (!rstN)
    (outMark && !outErr) |-> (outCtrl && outData == 8'hBC));

  a_r4_bad_high_block: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inCode[9:4] == 6'b111111) |=> (outErr && !outMark));
endmodule

bind b10_decoder b10_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inCode   (inCode),
  .outValid (outValid),
  .outData  (outData),
  .outCtrl  (outCtrl),
  .outErr   (outErr),
  .outMark  (outMark)
);

// File: tb/test_b10_decoder.sv
`timescale 1ns/1ps
module test_b10_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [9:0] inCode = '0;
  logic       outValid, outCtrl, outErr, outMark;
  logic [7:0] outData;
  int         checks = 0;
  int         failures = 0;
  logic       benchRd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b10_decoder i_b10_decoder (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inCode (inCode),
    .outValid (outValid), .outData (outData), .outCtrl (outCtrl),
    .outErr (outErr), .outMark (outMark)
  );

  // {negative-entry form, positive-entry form}
  function automatic logic [11:0] tab6(input int x);
    case (x)
      0:  return 12'b100111_011000;  1:  return 12'b011101_100010;
      2:  return 12'b101101_010010;  3:  return 12'b110001_110001;
      4:  return 12'b110101_001010;  5:  return 12'b101001_101001;
      6:  return 12'b011001_011001;  7:  return 12'b111000_000111;
      8:  return 12'b111001_000110;  9:  return 12'b100101_100101;
      10: return 12'b010101_010101;  11: return 12'b110100_110100;
      12: return 12'b001101_001101;  13: return 12'b101100_101100;
      14: return 12'b011100_011100;  15: return 12'b010111_101000;
      16: return 12'b011011_100100;  17: return 12'b100011_100011;
      18: return 12'b010011_010011;  19: return 12'b110010_110010;
      20: return 12'b001011_001011;  21: return 12'b101010_101010;
      22: return 12'b011010_011010;  23: return 12'b111010_000101;
      24: return 12'b110011_001100;  25: return 12'b100110_100110;
      26: return 12'b010110_010110;  27: return 12'b110110_001001;
      28: return 12'b001110_001110;  29: return 12'b101110_010001;
      30: return 12'b011110_100001;  default: return 12'b101011_010100;
    endcase
  endfunction

  function automatic logic [7:0] tab4(input int y);
    case (y)
      0: return 8'b1011_0100;  1: return 8'b1001_1001;
      2: return 8'b0101_0101;  3: return 8'b1100_0011;
      4: return 8'b1101_0010;  5: return 8'b1010_1010;
      6: return 8'b0110_0110;  default: return 8'b1110_0001;
    endcase
  endfunction

  // R7 update rule applied to the received bits
  function automatic logic rdAfter(input logic [9:0] c, input logic r);
    int   o6, o4;
    logic m;
    o6 = $countones(c[9:4]);
    o4 = $countones(c[3:0]);
    m  = (o6 == 3) ? r : (o6 > 3);
    return (o4 == 2) ? m : (o4 > 2);
  endfunction

  function automatic logic [9:0] encode(input logic [7:0] v, input logic k, input logic r);
    int         x, y, o6;
    logic [5:0] hi;
    logic [3:0] lo, posLo;
    logic       m, alt;
    x = int'(v[4:0]);
    y = int'(v[7:5]);
    if (k && x == 28) hi = r ? 6'b110000 : 6'b001111;
    else              hi = r ? tab6(x)[5:0] : tab6(x)[11:6];
    o6 = $countones(hi);
    m  = (o6 == 3) ? r : (o6 > 3);
    alt = (y == 7) && (k || (!m && (x == 17 || x == 18 || x == 20))
                         || (m && (x == 11 || x == 13 || x == 14)));
    posLo = tab4(y)[3:0];
    if (alt)              lo = m ? 4'b1000 : 4'b0111;
    else if (k && x == 28) lo = m ? posLo : ~posLo;
    else                  lo = m ? posLo : tab4(y)[7:4];
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [11:0] act,
                       input logic [11:0] exp, input logic [11:0] mask);
    checks++;
    if ((act & mask) != (exp & mask)) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act & mask, exp & mask);
    end
  endtask

  // drives one word, samples its result one clock later
  task automatic sendWord(input string tag, input logic [9:0] code, input logic eErr,
                          input logic eMark, input logic eCtrl, input logic [7:0] eData,
                          input bit dataCare);
    inValid = 1'b1;
    inCode  = code;
    @(posedge clk);
    benchRd = rdAfter(code, benchRd);
    @(negedge clk);
    check(tag, {outValid, outErr, outMark, outCtrl, outData},
          {1'b1, eErr, eMark, eCtrl, eData}, dataCare ? 12'hFFF : 12'hF00);
  endtask

  task automatic runReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset state", {outValid, outErr, outMark, outCtrl, outData}, 12'h000, 12'hFFF);
    rstN = 1'b1;
    benchRd = 1'b0;
    @(negedge clk);
    sendWord("R7 starts negative", 10'b001111_1010, 1'b0, 1'b1, 1'b1, 8'hBC, 1'b1);
    inValid = 1'b0;
  endtask

  task automatic runDataSweep();
    for (int v = 0; v < 256; v++)
      sendWord($sformatf("R1 data %0d", v), encode(8'(v), 1'b0, benchRd),
               1'b0, 1'b0, 1'b0, 8'(v), 1'b1);
    inValid = 1'b0;
  endtask

  task automatic runControl();
    logic [7:0] kList [12];
    for (int y = 0; y < 8; y++) kList[y] = {3'(y), 5'd28};
    kList[8] = 8'hF7; kList[9] = 8'hFB; kList[10] = 8'hFD; kList[11] = 8'hFE;
    for (int pol = 0; pol < 2; pol++) begin
      for (int i = 0; i < 12; i++) begin
        if (benchRd != pol[0])
          sendWord("R1 flip word", encode(8'h03, 1'b0, benchRd), 1'b0, 1'b0, 1'b0, 8'h03, 1'b1);
        sendWord((kList[i] == 8'hBC) ? "R3 comma mark" : "R2 control char",
                 encode(kList[i], 1'b1, benchRd), 1'b0, kList[i] == 8'hBC, 1'b1,
                 kList[i], 1'b1);
      end
    end
    inValid = 1'b0;
  endtask

  task automatic runInvalid();
    sendWord("R4 bad high block", 10'b111111_1011, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R4 low block all ones", 10'b110001_1111, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R4 low block all zeros", 10'b110001_0000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R4 wrong seven form", benchRd ? 10'b100011_1000 : 10'b100011_1110,
             1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    inValid = 1'b0;
  endtask

  task automatic runDisparity();
    sendWord("R5 comma wrong polarity", benchRd ? 10'b001111_1010 : 10'b110000_0101,
             1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    sendWord("R5 low block disparity", benchRd ? 10'b011000_0100 : 10'b100111_1011,
             1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    inValid = 1'b0;
  endtask

  task automatic runPriority();
    sendWord("R6 illegal beats disparity", benchRd ? 10'b001111_0001 : 10'b110000_1110,
             1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R6 disparity beats comma", benchRd ? 10'b001111_1010 : 10'b110000_0101,
             1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    inValid = 1'b0;
  endtask

  task automatic runRdOnError();
    sendWord("R7 illegal forces positive", 10'b111111_1011, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R7 positive-only word clean", 10'b011000_1011, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    sendWord("R7 illegal forces negative", 10'b000000_0100, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendWord("R7 negative-only word clean", 10'b100111_0100, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    inValid = 1'b0;
  endtask

  task automatic runIdle();
    logic [10:0] last;
    sendWord("R1 before gap", encode(8'h5A, 1'b0, benchRd), 1'b0, 1'b0, 1'b0, 8'h5A, 1'b1);
    last = {outErr, outMark, outCtrl, outData};
    inValid = 1'b0;
    inCode  = benchRd ? 10'b0000000000 : 10'b1111111111;
    repeat (3) begin
      @(negedge clk);
      check("R8 R9 idle gap", {outValid, outErr, outMark, outCtrl, outData},
            {1'b0, last}, 12'hFFF);
    end
    sendWord("R9 disparity kept R8 latency", encode(8'h00, 1'b0, benchRd),
             1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    inValid = 1'b0;
    @(negedge clk);
    check("R8 valid drops", {11'h0, outValid}, 12'h000, 12'h001);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    runReset();
    runDataSweep();
    runControl();
    runInvalid();
    runDisparity();
    runPriority();
    runRdOnError();
    runIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule